// File: doc/BRIEF.md
# I2C Target Front End with Selectable Address

This block is the bus-facing half of a small byte-addressed memory that sits on a two-wire I2C bus. It watches already-synchronised clock and data lines, finds START, repeated START and STOP conditions, and shifts bytes in and out. It pulls the data line low through an open-drain enable to acknowledge bytes and to send read data. It keeps one internal address counter that serves both directions. It tells the memory side where to write and what to write, and it asks for read bytes one at a time.

The block answers to one of two 7-bit addresses. A select pin chooses between them. With the pin low, the address is a fixed parameter, 51h by default, so the address byte is A2h for a write and A3h for a read. With the pin high, the address is bits 7:1 of the byte the memory holds at location 00h. A busy input from the memory side stops the block from acknowledging its address while a slow store is still in progress, so a controller can poll until the memory is ready.

A write transfer always gives the memory address first and then the data bytes. Writes stay inside one aligned page. Reads continue from wherever the counter stands and run linearly through the whole address space. To read from a chosen address, the controller first sends a write that carries only the address and then a repeated START.

Top module: `i2c_addr_target`

## Requirements
- R1: After reset the block does not drive the data line (sda_oe_o low), and it issues no write strobe and no read request until a matching address has been received.
- R2: A STOP releases the data line and returns the block to idle. A START or repeated START seen part way through a byte abandons that byte. Bytes clocked after a STOP and before the next START are not acknowledged and cause no writes.
- R3: The first byte after START holds the target address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). With addr_sel_i low, the byte is acknowledged only if it is A2h or A3h (the FIXED_ADDR parameter, 51h, shifted left by one).
- R4: With addr_sel_i high, the byte is acknowledged only if its bits 7:1 equal bits 7:1 of stored_addr_i. Bit 0 of stored_addr_i has no effect.
- R5: If the address does not match, the block does not acknowledge it. It then ignores all clocked bytes, with no acknowledge and no write, until the next START.
- R6: While busy_i is high when the address byte completes, the address is not acknowledged, even if it matches.
- R7: In a write transfer, the second byte loads the address counter. Each later byte gives one wr_stb_o pulse carrying the counter in wr_addr_o and the byte in wr_data_o, after which the counter advances. Every byte of a write transfer is acknowledged.
- R8: Write advances stay inside a PAGE_BYTES-aligned page (2 bytes by default): only the low log2(PAGE_BYTES) bits count, so a write past the page end wraps back to the page's first address.
- R9: A read transfer returns bytes starting at the current counter value. Each byte is requested with a one-cycle rd_req_o pulse carrying rd_addr_o, and rd_data_i is taken on the following clock cycle. The counter then advances linearly and wraps from FFh to 00h.
- R10: A write holding only the memory-address byte, followed by a repeated START and a read address byte, makes the read start at that memory address.
- R11: During a read, a controller acknowledge (data low in the ninth clock) requests the next byte. A NACK ends the transfer: the data line stays released and no further read request is made.
- R12: The data line enable turns on only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired value) |
| addr_sel_i | input | 1 | Low: fixed address; high: address from stored_addr_i |
| stored_addr_i | input | 8 | Byte held at memory location 00h |
| busy_i | input | 1 | Memory busy; blocks the address acknowledge |
| rd_data_i | input | 8 | Read byte, valid the cycle after rd_req_o |
| sda_oe_o | output | 1 | Open-drain enable: high pulls the data line low |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 8 | Read address |

## Verification
The bench builds the block with its defaults: an 8-bit address counter, a 2-byte page and fixed address 51h. With an 8-bit counter, the wrap from FFh to 00h appears after a dummy write to FFh and a two-byte read. With a 2-byte page, the write wrap appears on the third data byte of a single transfer. The fixed address lets the table of address bytes mix A2h/A3h matches with matches against a stored byte whose bit 0 is set, under both select levels and with busy raised.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_MADDR,
    ST_MADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges only count as conditions while the clock is steadily high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_tgt_addr_cmp.sv
module i2c_tgt_addr_cmp #(
  parameter logic [6:0] FIXED_ADDR = 7'h51
) (
  input  logic       sel_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] stored_i,
  output logic       hit_o
);

  logic [6:0] target;

  assign target = sel_i ? stored_i[7:1] : FIXED_ADDR;
  assign hit_o  = (byte_i[7:1] == target);

  // the direction bit and the stored byte's low bit take no part in matching
  logic unused_ok;
  assign unused_ok = &{1'b0, byte_i[0], stored_i[0]};

endmodule

// File: rtl/i2c_tgt_addr_cnt.sv
module i2c_tgt_addr_cnt #(
  parameter int AW         = 8,
  parameter int PAGE_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          wr_adv,
  input  logic          rd_adv,
  output logic [AW-1:0] cnt_o
);

  localparam int PB = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 0;

  logic [AW-1:0] cnt_q, cnt_d, page_next;

  generate
    if (PB == 0) begin : g_no_page
      assign page_next = cnt_q;
    end else if (PB >= AW) begin : g_full_page
      assign page_next = cnt_q + AW'(1);
    end else begin : g_page
      assign page_next = {cnt_q[AW-1:PB], PB'(cnt_q[PB-1:0] + 1'b1)};

      assert_page_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_adv && !load_en) |=> (cnt_q[AW-1:PB] == $past(cnt_q[AW-1:PB])));
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)     cnt_d = load_val;
    else if (wr_adv) cnt_d = page_next;
    else if (rd_adv) cnt_d = cnt_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_read_linear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !load_en && !wr_adv) |=> (cnt_q == $past(cnt_q) + AW'(1)));

endmodule

// File: rtl/i2c_addr_target.sv
module i2c_addr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] FIXED_ADDR = 7'h51,
  parameter int         AW         = 8,
  parameter int         PAGE_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          addr_sel_i,
  input  logic [7:0]    stored_addr_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);

  localparam int BW = $clog2(BYTE_W + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_line_mon u_line (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  tgt_state_e        state_q, state_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [BYTE_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic              oe_q, oe_d;
  logic              dir_rd_q, dir_rd_d;
  logic              acked_q, acked_d;
  logic              rd_pend_q, rd_pend_d;
  logic              wr_stb_q, wr_stb_d;
  logic [AW-1:0]     wr_addr_q, wr_addr_d;
  logic [7:0]        wr_data_q, wr_data_d;
  logic              rd_req_q, rd_req_d;
  logic [AW-1:0]     rd_addr_q, rd_addr_d;

  logic          cnt_load, cnt_wr_adv, cnt_rd_adv;
  logic [AW-1:0] cnt;
  logic          addr_hit, byte_done;

  i2c_tgt_addr_cmp #(.FIXED_ADDR(FIXED_ADDR)) u_cmp (
    .sel_i   (addr_sel_i),
    .byte_i  (rx_q),
    .stored_i(stored_addr_i),
    .hit_o   (addr_hit)
  );

  i2c_tgt_addr_cnt #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (cnt_load),
    .load_val(AW'(rx_q)),
    .wr_adv  (cnt_wr_adv),
    .rd_adv  (cnt_rd_adv),
    .cnt_o   (cnt)
  );

  assign byte_done = scl_fall && (bit_q == BW'(BYTE_W));

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    oe_d       = oe_q;
    dir_rd_d   = dir_rd_q;
    acked_d    = acked_q;
    rd_pend_d  = rd_req_q;
    wr_stb_d   = 1'b0;
    wr_addr_d  = wr_addr_q;
    wr_data_d  = wr_data_q;
    rd_req_d   = 1'b0;
    rd_addr_d  = rd_addr_q;
    cnt_load   = 1'b0;
    cnt_wr_adv = 1'b0;
    cnt_rd_adv = 1'b0;

    // read data arrives the cycle after the request
    if (rd_pend_q) tx_d = rd_data_i;

    if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
      acked_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      acked_d = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_MADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_i};
            bit_d = bit_q + BW'(1);
          end
          if (byte_done) begin
            bit_d = '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit && !busy_i) begin
                oe_d     = 1'b1;
                dir_rd_d = rx_q[0];
                state_d  = ST_ADDR_ACK;
                if (rx_q[0]) begin
                  rd_req_d   = 1'b1;
                  rd_addr_d  = cnt;
                  cnt_rd_adv = 1'b1;
                end
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_MADDR) begin
              cnt_load = 1'b1;
              oe_d     = 1'b1;
              state_d  = ST_MADDR_ACK;
            end else begin
              wr_stb_d   = 1'b1;
              wr_addr_d  = cnt;
              wr_data_d  = rx_q;
              cnt_wr_adv = 1'b1;
              oe_d       = 1'b1;
              state_d    = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (dir_rd_q) begin
              state_d = ST_RDATA;
              oe_d    = ~tx_q[BYTE_W-1];
            end else begin
              state_d = ST_MADDR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_MADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            bit_d   = '0;
            oe_d    = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) bit_d = bit_q + BW'(1);
          if (scl_fall) begin
            if (bit_q == BW'(BYTE_W)) begin
              oe_d    = 1'b0;
              acked_d = 1'b0;
              state_d = ST_RACK;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (!sda_i) begin
              acked_d    = 1'b1;
              rd_req_d   = 1'b1;
              rd_addr_d  = cnt;
              cnt_rd_adv = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
          if (scl_fall && acked_q) begin
            acked_d = 1'b0;
            bit_d   = '0;
            oe_d    = ~tx_q[BYTE_W-1];
            state_d = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
      dir_rd_q  <= 1'b0;
      acked_q   <= 1'b0;
      rd_pend_q <= 1'b0;
      wr_stb_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      oe_q      <= oe_d;
      dir_rd_q  <= dir_rd_d;
      acked_q   <= acked_d;
      rd_pend_q <= rd_pend_d;
      wr_stb_q  <= wr_stb_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      rd_req_q  <= rd_req_d;
      rd_addr_q <= rd_addr_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_stb_o  = wr_stb_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign rd_req_o  = rd_req_q;
  assign rd_addr_o = rd_addr_q;

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    stop_det |=> (!sda_oe_o && state_q == ST_IDLE));

  assert_mismatch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_ADDR && byte_done && !addr_hit) |=> (!sda_oe_o && state_q == ST_IDLE));

  assert_busy_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_ADDR && byte_done && busy_i) |=> !sda_oe_o);

  assert_write_acked_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb_o |-> sda_oe_o);

  assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sda_oe_o) |-> !scl_i);

endmodule

// File: tb/test_i2c_addr_target.sv
module test_i2c_addr_target;

  localparam int Q = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ctl_scl, ctl_sda, sel, busy;
  logic [7:0] rd_data;
  logic [7:0] mem [256];
  logic sda_oe, wr_stb, rd_req;
  logic [7:0] wr_addr, wr_data, rd_addr;
  wire  sda_bus = ctl_sda & ~sda_oe;
  wire [7:0] stored = mem[0];

  int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0, r12_bad = 0;
  logic oe_prev = 1'b0;

  i2c_addr_target i_i2c_addr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(ctl_scl), .sda_i(sda_bus),
    .addr_sel_i(sel), .stored_addr_i(stored), .busy_i(busy), .rd_data_i(rd_data),
    .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr)
  );

  // memory model: location 0 holds B5h (address 5Ah, bit 0 set), others i^5Ah
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i == 0) ? 8'hB5 : (8'(i) ^ 8'h5A);
      rd_data <= 8'h00;
    end else begin
      if (wr_stb) begin mem[wr_addr] <= wr_data; wr_cnt <= wr_cnt + 1; end
      if (rd_req) begin rd_data <= mem[rd_addr]; rd_cnt <= rd_cnt + 1; end
    end
  end

  // R12 monitor: enable may only rise while the clock line is low
  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (rst_n && sda_oe && !oe_prev && ctl_scl) r12_bad <= r12_bad + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    ctl_sda = 1'b1; wq(Q); ctl_scl = 1'b1; wq(Q); ctl_sda = 1'b0; wq(Q); ctl_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    ctl_sda = 1'b0; wq(Q); ctl_scl = 1'b1; wq(Q); ctl_sda = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    ctl_sda = b; wq(Q); ctl_scl = 1'b1; wq(2*Q); ctl_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    ctl_sda = 1'b1; wq(Q); ctl_scl = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); ctl_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      ctl_sda = 1'b1; wq(Q); ctl_scl = 1'b1; wq(Q); d = {d[6:0], sda_bus}; wq(Q); ctl_scl = 1'b0; wq(Q);
    end
    put_bit(nack);
  endtask

  // {addr_sel, busy, address byte, expected ack}
  localparam logic [10:0] VEC [9] = '{
    {1'b0, 1'b0, 8'hA2, 1'b1},   // R3 fixed write
    {1'b0, 1'b0, 8'hA3, 1'b1},   // R3 fixed read
    {1'b0, 1'b0, 8'hA4, 1'b0},   // R5 wrong address
    {1'b0, 1'b0, 8'hB4, 1'b0},   // R3 stored value ignored when select low
    {1'b1, 1'b0, 8'hB4, 1'b1},   // R4 stored address, bit 0 of stored byte ignored
    {1'b1, 1'b0, 8'hB5, 1'b1},   // R4 stored address, read
    {1'b1, 1'b0, 8'hA2, 1'b0},   // R4 fixed address not used when select high
    {1'b0, 1'b1, 8'hA2, 1'b0},   // R6 busy
    {1'b1, 1'b1, 8'hB4, 1'b0}    // R6 busy with stored address
  };

  initial begin
    logic ack;
    logic [7:0] d;
    int w0, r0;
    rst_n = 1'b0; ctl_scl = 1'b1; ctl_sda = 1'b1; sel = 1'b0; busy = 1'b0;
    wq(5); rst_n = 1'b1; wq(5);

    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 no strobes after reset", wr_cnt + rd_cnt, 0);

    for (int v = 0; v < 9; v++) begin
      sel = VEC[v][10]; busy = VEC[v][9];
      bus_start;
      send_byte(VEC[v][8:1], ack);
      chk($sformatf("R3/R4/R5/R6 address vector %0d ack", v), ack, VEC[v][0]);
      if (ack && VEC[v][1]) recv_byte(1'b1, d);
      bus_stop;
      busy = 1'b0;
    end
    sel = 1'b0;

    // R7 plain write
    w0 = wr_cnt;
    bus_start; send_byte(8'hA2, ack); send_byte(8'h10, ack); send_byte(8'h11, ack);
    chk("R7 data byte acked", ack, 1);
    send_byte(8'h22, ack); bus_stop;
    chk("R7 mem[10]", mem[8'h10], 8'h11);
    chk("R7 mem[11]", mem[8'h11], 8'h22);
    chk("R7 write count", wr_cnt - w0, 2);
    chk("R2 released after stop", sda_oe, 0);

    // R8 page wrap: 21 <- AA, 20 <- BB, 21 <- CC
    bus_start; send_byte(8'hA2, ack); send_byte(8'h21, ack);
    send_byte(8'hAA, ack); send_byte(8'hBB, ack); send_byte(8'hCC, ack); bus_stop;
    chk("R8 mem[20]", mem[8'h20], 8'hBB);
    chk("R8 mem[21]", mem[8'h21], 8'hCC);
    chk("R8 mem[22] untouched", mem[8'h22], 8'h22 ^ 8'h5A);

    // R10/R11 dummy write then sequential read
    r0 = rd_cnt;
    bus_start; send_byte(8'hA2, ack); send_byte(8'h10, ack);
    bus_start; send_byte(8'hA3, ack);
    recv_byte(1'b0, d); chk("R10 first read byte", d, 8'h11);
    recv_byte(1'b1, d); chk("R11 second read byte", d, 8'h22);
    wq(4*Q);
    chk("R11 released after nack", sda_oe, 0);
    chk("R11 read requests", rd_cnt - r0, 2);
    bus_stop;

    // R9 current-address read continues at 12h
    bus_start; send_byte(8'hA3, ack); recv_byte(1'b1, d); bus_stop;
    chk("R9 current read", d, 8'h12 ^ 8'h5A);

    // R9 wrap from FF to 00
    bus_start; send_byte(8'hA2, ack); send_byte(8'hFF, ack);
    bus_start; send_byte(8'hA3, ack);
    recv_byte(1'b0, d); chk("R9 read at FF", d, 8'hFF ^ 8'h5A);
    recv_byte(1'b1, d); chk("R9 read wraps to 00", d, 8'hB5);
    bus_stop;

    // R5 mismatch then bytes ignored until next START
    w0 = wr_cnt;
    bus_start; send_byte(8'hA4, ack); send_byte(8'h10, ack);
    chk("R5 byte after mismatch not acked", ack, 0);
    send_byte(8'h77, ack); bus_stop;
    chk("R5 no write after mismatch", wr_cnt - w0, 0);
    chk("R5 mem[10] kept", mem[8'h10], 8'h11);

    // R2 repeated START mid-byte abandons the byte
    w0 = wr_cnt;
    bus_start; send_byte(8'hA2, ack); send_byte(8'h10, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start; send_byte(8'hA2, ack); send_byte(8'h10, ack); send_byte(8'h99, ack); bus_stop;
    chk("R2 mem[10] after abort", mem[8'h10], 8'h99);
    chk("R2 single write after abort", wr_cnt - w0, 1);

    // R2 bytes after STOP without START are ignored
    w0 = wr_cnt;
    send_byte(8'hA2, ack);
    chk("R2 no ack without START", ack, 0);
    send_byte(8'h10, ack); send_byte(8'h33, ack); bus_stop;
    chk("R2 no write without START", wr_cnt - w0, 0);

    chk("R12 enable rose only while SCL low", r12_bad, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule